// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with LIN Host Header

This block turns a data word into an asynchronous serial frame on a single line. A write carries the word. The frame then goes out as a low start bit, five to nine data bits with the least significant bit first, an optional parity bit and one or two high stop bits. Bit timing comes from an external baud tick: the line changes only on clock edges where the tick is high, so one bit lasts one tick interval. The line idles high.

In LIN host mode the same write can start a header sequence. One command sends a break field (thirteen low bit times and a one-bit high delimiter) ahead of the character. A second command sends the break, then the sync byte 0x55, then the written word as the identifier. A busy flag covers the whole sequence. A transmit-enable input switches the block on. When that input is cleared, the block switches off only once all work in flight has left the line.

Top module: `sertx_lin`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0 and `tx_on` is 0.
- R2: A character frame is a 0 start bit followed by the data bits, least significant first. The number of data bits comes from `size_code`: 5, 6 and 7 give that many bits, 0 gives 8 bits, 1 gives 9 bits, and the reserved codes 2, 3 and 4 give 8 bits.
- R3: With `parity_en` high, one parity bit follows the data bits. If `parity_odd` is 0 it makes the count of ones in data plus parity even. If `parity_odd` is 1 it makes that count odd. With `parity_en` low no parity bit is sent.
- R4: The frame ends with one stop bit (value 1) when `two_stop` is 0 and with two stop bits when `two_stop` is 1.
- R5: `txd` changes only at clock edges where `baud_tick` is high. Each bit is held for exactly one tick interval. Frames in a sequence follow each other with no idle gap.
- R6: With `lin_host` high and `lin_cmd` = 1, a write sends 13 low bits and then 1 high delimiter bit, followed by the written character in the configured format.
- R7: With `lin_host` high and `lin_cmd` = 2, a write sends the break and the delimiter, then the sync byte 0x55 as 8 data bits with no parity and one stop bit, then the written word as the identifier in the configured format.
- R8: With `lin_host` low, or with `lin_cmd` = 3, the command is ignored and a write sends only the plain character.
- R9: A write is accepted at a clock edge where `wr_valid` is high, `tx_on` is 1 and `busy` is 0. `busy` is 1 from the next cycle until the edge that ends the last stop bit of the sequence. Writes while busy are ignored, and `txd` is 1 whenever `busy` is 0.
- R10: `tx_on` becomes 1 one cycle after `tx_enable` is high. After `tx_enable` is cleared, `tx_on` stays 1 until `busy` is 0 and then drops, so the sequence in flight completes in full. Writes while `tx_on` is 0 are ignored.
- R11: The data word and every format and command input are captured when the write is accepted. Changing them while busy does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_enable | input | 1 | Transmitter enable request |
| lin_host | input | 1 | LIN host mode select |
| lin_cmd | input | 2 | Header command: 0 plain, 1 break, 2 full header, 3 reserved |
| size_code | input | 3 | Character size code |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | 0 even parity, 1 odd parity |
| two_stop | input | 1 | 0 one stop bit, 1 two stop bits |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | 9 | Data word or identifier |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Sequence in progress |
| tx_on | output | 1 | Transmitter effectively enabled |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse that recurs at least every few cycles, and that `wr_valid` is a synchronous strobe. They make no assumption about when writes occur relative to ticks. The stimulus drives every input at the falling clock edge. It spaces ticks three cycles apart and lets writes land at arbitrary phases of the tick cycle. It also deliberately issues writes while busy or disabled and changes the format inputs mid-sequence, so the assertions about the idle line, tick-aligned changes and enable hand-off are exercised outside the plain path.

// File: rtl/sertx_pkg.sv
// Package: shared types and helpers for the serial transmitter.
// Assumes: character sizes between 5 and 9 data bits.
package sertx_pkg;

    // Kind of frame the shifter is asked to send.
    typedef enum logic [1:0] {
        K_CHAR  = 2'd0,
        K_BREAK = 2'd1,
        K_SYNC  = 2'd2
    } frame_kind_t;

    // Sequence selected at write time.
    typedef enum logic [1:0] {
        M_PLAIN  = 2'd0,
        M_BREAK  = 2'd1,
        M_HEADER = 2'd2
    } seq_mode_t;

    // Character format captured with each write.
    typedef struct packed {
        logic [2:0] size_code;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } char_cfg_t;

    // Data bits for a size code; reserved codes fall back to 8.
    function automatic int unsigned data_bits(input logic [2:0] code);
        case (code)
            3'd1:    data_bits = 9;
            3'd5:    data_bits = 5;
            3'd6:    data_bits = 6;
            3'd7:    data_bits = 7;
            default: data_bits = 8;
        endcase
    endfunction

    // Sequence mode from the header command; only honoured in host mode.
    function automatic seq_mode_t decode_mode(input logic host, input logic [1:0] cmd);
        if (!host)            decode_mode = M_PLAIN;
        else if (cmd == 2'd1) decode_mode = M_BREAK;
        else if (cmd == 2'd2) decode_mode = M_HEADER;
        else                  decode_mode = M_PLAIN;
    endfunction

endpackage

// File: rtl/sertx_enable.sv
// Module: sertx_enable
// Tracks the effective transmitter enable. A set request applies on the
// next edge. A clear request waits until no sequence is active or starting.
// Assumes: busy and accept come from the sequencer in the same clock domain.
module sertx_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_enable,
    input  logic busy,
    input  logic accept,
    output logic tx_on
);

    logic on_q;

    // Effective enable register with deferred clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q <= 1'b0;
        end else if (tx_enable) begin
            on_q <= 1'b1;
        end else if (!busy && !accept) begin
            on_q <= 1'b0;
        end
    end

    assign tx_on = on_q;

endmodule

// File: rtl/sertx_seq.sv
// Module: sertx_seq
// Accepts writes, captures data and format, and steps through the frames of
// a sequence (break, sync, character). It asks the shifter to load each
// frame: the first one the cycle after acceptance, later ones at the end
// of the previous frame.
// Assumes: frame_done pulses once, on the tick that ends a frame.
module sertx_seq
    import sertx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  char_cfg_t         cfg_in,
    input  logic              lin_host,
    input  logic [1:0]        lin_cmd,
    input  logic              tx_on,
    input  logic              frame_done,
    output logic              accept,
    output logic              busy,
    output logic              ld,
    output frame_kind_t       ld_kind,
    output logic [DATA_W-1:0] data_q,
    output char_cfg_t         cfg_q
);

    logic        busy_q;
    logic        pend_q;
    frame_kind_t kind_q;
    seq_mode_t   mode_q;
    seq_mode_t   mode_in;
    frame_kind_t first_kind;
    frame_kind_t nxt_kind;
    logic        has_next;

    assign accept     = wr_valid && tx_on && !busy_q;
    assign mode_in    = decode_mode(lin_host, lin_cmd);
    assign first_kind = (mode_in == M_PLAIN) ? K_CHAR : K_BREAK;

    // Successor frame of the one in flight, if the sequence has one.
    always_comb begin
        has_next = 1'b0;
        nxt_kind = K_CHAR;
        case (kind_q)
            K_BREAK: begin
                has_next = 1'b1;
                nxt_kind = (mode_q == M_HEADER) ? K_SYNC : K_CHAR;
            end
            K_SYNC: begin
                has_next = 1'b1;
                nxt_kind = K_CHAR;
            end
            default: begin
                has_next = 1'b0;
                nxt_kind = K_CHAR;
            end
        endcase
    end

    assign ld      = pend_q || (frame_done && has_next);
    assign ld_kind = pend_q ? kind_q : nxt_kind;

    // Sequence state: capture on accept, advance on frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
            kind_q <= K_CHAR;
            mode_q <= M_PLAIN;
            data_q <= '0;
            cfg_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            pend_q <= 1'b1;
            kind_q <= first_kind;
            mode_q <= mode_in;
            data_q <= wr_data;
            cfg_q  <= cfg_in;
        end else begin
            pend_q <= 1'b0;
            if (frame_done) begin
                if (has_next) begin
                    kind_q <= nxt_kind;
                end else begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign busy = busy_q;

endmodule

// File: rtl/sertx_framer.sv
// Module: sertx_framer
// Builds the bit image of one frame, bit 0 sent first, plus its length.
// Break: BRK_BITS low bits then one high delimiter. Sync: the sync byte as
// 8 data bits, no parity, one stop. Character: start, data LSB first,
// optional parity, one or two stops. Unused upper bits read as 1.
// Assumes: FRAME_W covers the longest frame.
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int          DATA_W    = 9,
    parameter int          BRK_BITS  = 13,
    parameter logic [7:0]  SYNC_BYTE = 8'h55,
    parameter int          FRAME_W   = 14,
    parameter int          LEN_W     = 4
) (
    input  frame_kind_t       kind,
    input  logic [DATA_W-1:0] data,
    input  char_cfg_t         cfg,
    output logic [FRAME_W-1:0] bits,
    output logic [LEN_W-1:0]   len
);

    // Frame image assembly for the selected kind.
    always_comb begin
        int unsigned nbits;
        int unsigned pos;
        logic        par;
        bits  = '1;
        len   = '0;
        nbits = data_bits(cfg.size_code);
        pos   = 0;
        par   = cfg.par_odd;
        case (kind)
            K_BREAK: begin
                for (int i = 0; i < FRAME_W; i++) begin
                    bits[i] = (i >= BRK_BITS);
                end
                len = LEN_W'(BRK_BITS + 1);
            end
            K_SYNC: begin
                bits[0] = 1'b0;
                for (int i = 0; i < 8; i++) begin
                    bits[i+1] = SYNC_BYTE[i];
                end
                bits[9] = 1'b1;
                len = LEN_W'(10);
            end
            default: begin
                bits[0] = 1'b0;
                for (int i = 0; i < DATA_W; i++) begin
                    if (i < nbits) begin
                        bits[i+1] = data[i];
                        par       = par ^ data[i];
                    end
                end
                pos = nbits + 1;
                if (cfg.par_en) begin
                    bits[pos] = par;
                    pos       = pos + 1;
                end
                len = LEN_W'(pos + 1 + (cfg.two_stop ? 1 : 0));
            end
        endcase
    end

endmodule

// File: rtl/sertx_shifter.sv
// Module: sertx_shifter
// Drives the line from a frame image, one bit per baud tick. A frame
// loaded while idle waits for the next tick. A frame loaded on the
// finishing tick of the previous one starts at once, with no gap.
// Assumes: ld arrives only while idle or on the done tick.
module sertx_shifter #(
    parameter int FRAME_W = 14,
    parameter int LEN_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               ld,
    input  logic [FRAME_W-1:0] ld_bits,
    input  logic [LEN_W-1:0]   ld_len,
    output logic               txd,
    output logic               done
);

    logic [FRAME_W-1:0] sreg;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   cnt;
    logic               armed;
    logic               active;
    logic               txd_q;

    assign done = active && tick && (cnt == len_q);

    // Bit sequencing of the line output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '1;
            len_q  <= '0;
            cnt    <= '0;
            armed  <= 1'b0;
            active <= 1'b0;
            txd_q  <= 1'b1;
        end else if (ld && (done || tick)) begin
            txd_q  <= ld_bits[0];
            sreg   <= {1'b1, ld_bits[FRAME_W-1:1]};
            len_q  <= ld_len;
            cnt    <= LEN_W'(1);
            active <= 1'b1;
            armed  <= 1'b0;
        end else if (ld) begin
            sreg   <= ld_bits;
            len_q  <= ld_len;
            armed  <= 1'b1;
        end else if (tick && armed) begin
            txd_q  <= sreg[0];
            sreg   <= {1'b1, sreg[FRAME_W-1:1]};
            cnt    <= LEN_W'(1);
            active <= 1'b1;
            armed  <= 1'b0;
        end else if (done) begin
            active <= 1'b0;
            txd_q  <= 1'b1;
        end else if (tick && active) begin
            txd_q  <= sreg[0];
            sreg   <= {1'b1, sreg[FRAME_W-1:1]};
            cnt    <= cnt + LEN_W'(1);
        end
    end

    assign txd = txd_q;

endmodule

// File: rtl/sertx_lin.sv
// Module: sertx_lin (top)
// Asynchronous serial transmitter with optional LIN host header sequences.
// Ties together the enable tracker, the sequencer, the frame builder and
// the bit shifter.
// Assumes: baud_tick is a one-cycle pulse in the clk domain.
module sertx_lin
    import sertx_pkg::*;
#(
    parameter int         DATA_W    = 9,
    parameter int         BRK_BITS  = 13,
    parameter logic [7:0] SYNC_BYTE = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_enable,
    input  logic              lin_host,
    input  logic [1:0]        lin_cmd,
    input  logic [2:0]        size_code,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              two_stop,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              busy,
    output logic              tx_on
);

    localparam int CHAR_MAX = 1 + DATA_W + 1 + 2;
    localparam int FRAME_W  = (CHAR_MAX > BRK_BITS + 1) ? CHAR_MAX : BRK_BITS + 1;
    localparam int LEN_W    = $clog2(FRAME_W + 1);

    char_cfg_t          cfg_in;
    char_cfg_t          cfg_q;
    logic [DATA_W-1:0]  data_q;
    logic               accept;
    logic               busy_w;
    logic               ld;
    frame_kind_t        ld_kind;
    logic [FRAME_W-1:0] frm_bits;
    logic [LEN_W-1:0]   frm_len;
    logic               frame_done;

    assign cfg_in = '{size_code: size_code, par_en: parity_en,
                      par_odd: parity_odd, two_stop: two_stop};

    sertx_enable u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_enable (tx_enable),
        .busy      (busy_w),
        .accept    (accept),
        .tx_on     (tx_on)
    );

    sertx_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .cfg_in     (cfg_in),
        .lin_host   (lin_host),
        .lin_cmd    (lin_cmd),
        .tx_on      (tx_on),
        .frame_done (frame_done),
        .accept     (accept),
        .busy       (busy_w),
        .ld         (ld),
        .ld_kind    (ld_kind),
        .data_q     (data_q),
        .cfg_q      (cfg_q)
    );

    sertx_framer #(
        .DATA_W    (DATA_W),
        .BRK_BITS  (BRK_BITS),
        .SYNC_BYTE (SYNC_BYTE),
        .FRAME_W   (FRAME_W),
        .LEN_W     (LEN_W)
    ) u_framer (
        .kind (ld_kind),
        .data (data_q),
        .cfg  (cfg_q),
        .bits (frm_bits),
        .len  (frm_len)
    );

    sertx_shifter #(
        .FRAME_W (FRAME_W),
        .LEN_W   (LEN_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .ld      (ld),
        .ld_bits (frm_bits),
        .ld_len  (frm_len),
        .txd     (txd),
        .done    (frame_done)
    );

    assign busy = busy_w;

endmodule

// File: rtl/sertx_lin_chk.sv
// Module: sertx_lin_chk
// Port-level protocol checks for sertx_lin, attached by bind.
// Assumes: synchronous active-low reset.
module sertx_lin_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic tx_enable,
    input logic wr_valid,
    input logic txd,
    input logic busy,
    input logic tx_on
);

    // R9
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R5
    txd_tick_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(txd));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(wr_valid) && $past(tx_on)));

    // R10
    busy_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> tx_on);

    // R10
    off_drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_on) |-> (!$past(busy) && !$past(tx_enable)));

    // R10
    off_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_on && !busy) |=> !busy);

endmodule

bind sertx_lin sertx_lin_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .tx_enable (tx_enable),
    .wr_valid  (wr_valid),
    .txd       (txd),
    .busy      (busy),
    .tx_on     (tx_on)
);

// File: tb/sertx_lin_tb.sv
module sertx_lin_tb;

    localparam int TDIV = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_enable = 1'b0;
    logic       lin_host = 1'b0;
    logic [1:0] lin_cmd = '0;
    logic [2:0] size_code = '0;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       wr_valid = 1'b0;
    logic [8:0] wr_data = '0;
    logic       txd;
    logic       busy;
    logic       tx_on;

    int  n_run = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    bit  cap_q[$];
    bit  exp_q[$];
    int  tcnt = 0;
    bit  prev_busy = 1'b0;

    always #2.5ns clk = ~clk;

    sertx_lin u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .tx_enable  (tx_enable),
        .lin_host   (lin_host),
        .lin_cmd    (lin_cmd),
        .size_code  (size_code),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .two_stop   (two_stop),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .txd        (txd),
        .busy       (busy),
        .tx_on      (tx_on)
    );

    // Tick generation and capture of each bit the line shows while busy.
    always @(negedge clk) begin
        if (baud_tick && prev_busy && busy) cap_q.push_back(txd);
        prev_busy = busy;
        tcnt      = (tcnt == TDIV - 1) ? 0 : tcnt + 1;
        baud_tick = (tcnt == 0);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_width(input logic [2:0] code);
        case (code)
            3'd1: return 9;
            3'd5: return 5;
            3'd6: return 6;
            3'd7: return 7;
            default: return 8;
        endcase
    endfunction

    task automatic push_char(input logic [8:0] d, input int n, input bit pe,
                             input bit po, input bit ts);
        bit p = po;
        exp_q.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(d[i]);
            p ^= d[i];
        end
        if (pe) exp_q.push_back(p);
        exp_q.push_back(1'b1);
        if (ts) exp_q.push_back(1'b1);
    endtask

    task automatic build_exp(input logic [8:0] d, input logic [2:0] sc, input bit pe,
                             input bit po, input bit ts, input bit lh,
                             input logic [1:0] cmd);
        exp_q.delete();
        if (lh && (cmd == 2'd1 || cmd == 2'd2)) begin
            for (int i = 0; i < 13; i++) exp_q.push_back(1'b0);
            exp_q.push_back(1'b1);
            if (cmd == 2'd2) push_char(9'h055, 8, 1'b0, 1'b0, 1'b0);
        end
        push_char(d, exp_width(sc), pe, po, ts);
    endtask

    // One write, optional disturbances while busy, then stream comparison.
    task automatic run_frame(input logic [8:0] d, input logic [2:0] sc, input bit pe,
                             input bit po, input bit ts, input bit lh,
                             input logic [1:0] cmd, input string req,
                             input bit mid_change, input bit mid_write,
                             input int phase);
        int guard;
        int mism;
        repeat (phase) @(negedge clk);
        size_code = sc; parity_en = pe; parity_odd = po; two_stop = ts;
        lin_host = lh; lin_cmd = cmd;
        build_exp(d, sc, pe, po, ts, lh, cmd);
        cap_q.delete();
        wr_data = d; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(busy === 1'b1, "R9", "busy after accepted write", busy, 1);
        if (mid_write) begin
            repeat (7) @(negedge clk);
            wr_data = ~d; wr_valid = 1'b1;
            @(negedge clk);
            wr_valid = 1'b0;
        end
        if (mid_change) begin
            repeat (12) @(negedge clk);
            size_code = sc ^ 3'd2; parity_en = ~pe; parity_odd = ~po;
            two_stop = ~ts; lin_host = ~lh; lin_cmd = cmd ^ 2'd3;
            wr_data = ~d;
        end
        guard = 0;
        while (busy === 1'b1 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk(busy === 1'b0, "R9", "busy released", busy, 0);
        chk(cap_q.size() == exp_q.size(), req, "bit count", cap_q.size(), exp_q.size());
        mism = -1;
        for (int i = 0; i < exp_q.size() && i < cap_q.size(); i++) begin
            if (mism < 0 && cap_q[i] != exp_q[i]) mism = i;
        end
        chk(mism < 0, req, "first mismatching bit index", mism, -1);
        chk(txd === 1'b1, "R9", "line idle after sequence", txd, 1);
        if (mid_write) begin
            repeat (2 * TDIV + 2) @(negedge clk);
            chk(busy === 1'b0, "R9", "write while busy left no sequence", busy, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd === 1'b1, "R1", "txd after reset", txd, 1);
        chk(busy === 1'b0, "R1", "busy after reset", busy, 0);
        chk(tx_on === 1'b0, "R1", "tx_on after reset", tx_on, 0);

        // R10 write while disabled is ignored
        cap_q.delete();
        wr_data = 9'h0A5; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        repeat (30) @(negedge clk);
        chk(busy === 1'b0, "R10", "busy after write while off", busy, 0);
        chk(txd === 1'b1, "R10", "txd after write while off", txd, 1);
        chk(cap_q.size() == 0, "R10", "bits sent while off", cap_q.size(), 0);

        tx_enable = 1'b1;
        @(negedge clk);
        chk(tx_on === 1'b1, "R10", "tx_on one cycle after enable", tx_on, 1);

        // R2 every size code, including reserved ones
        for (int c = 0; c < 8; c++) begin
            run_frame(9'h1B3, 3'(c), 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, "R2", 1'b0, 1'b0, c % 3);
        end
        // R3 even and odd parity, R4 stop counts
        run_frame(9'h0B5, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, "R3", 1'b0, 1'b0, 0);
        run_frame(9'h0B5, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R3", 1'b0, 1'b0, 1);
        run_frame(9'h1FF, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, "R4", 1'b0, 1'b0, 2);
        run_frame(9'h000, 3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, "R4", 1'b0, 1'b0, 0);
        // R6 break then character, R7 full header
        run_frame(9'h03C, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, "R6", 1'b0, 1'b0, 1);
        run_frame(9'h0C1, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, "R7", 1'b0, 1'b0, 0);
        // R8 command ignored outside host mode, reserved command plain
        run_frame(9'h0C1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, "R8", 1'b0, 1'b0, 2);
        run_frame(9'h071, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, "R8", 1'b0, 1'b0, 1);
        // R11 inputs changed while busy; R9 write while busy ignored
        run_frame(9'h0E6, 3'd6, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, "R11", 1'b1, 1'b0, 0);
        run_frame(9'h05A, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, "R9", 1'b0, 1'b1, 2);

        // R10 disable mid-sequence completes the sequence first
        fork
            run_frame(9'h0A3, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2, "R10", 1'b0, 1'b0, 0);
            begin
                repeat (20) @(negedge clk);
                tx_enable = 1'b0;
                repeat (10) @(negedge clk);
                chk(tx_on === 1'b1, "R10", "tx_on held while busy", tx_on, 1);
            end
        join
        repeat (2) @(negedge clk);
        chk(tx_on === 1'b0, "R10", "tx_on after sequence with enable low", tx_on, 0);
        tx_enable = 1'b1;
        @(negedge clk);

        // R5 random mix over all formats and commands
        for (int k = 0; k < 30; k++) begin
            run_frame(9'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom), 2'($urandom), "R5",
                      ($urandom % 4) == 0, 1'b0, $urandom % 3);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule